// File: doc/BRIEF.md
# Supervisory Watchdog and Reset Timer

This block supervises a processor. It drives an active-low reset and watches a watchdog input for transitions. After the system reset, after a supply failure clears, and after every watchdog expiry, it holds its reset output low for a selectable number of timebase ticks and then releases it. Once reset releases, the watchdog counter starts. Any edge on the watchdog input, rising or falling, clears that counter. If the counter reaches its period, the active-low watchdog status output drops and a new reset pulse begins.

The watchdog period depends on history. Right after any reset, a long grace period applies. The shorter normal period takes over only after software has toggled the watchdog input for the first time. Two timing modes exist. In the external-clock mode, timebase ticks count directly with a 4096-tick grace period and a 1024-tick normal period. In the internal mode, a period select chooses either a fixed long period of 16384 ticks or a short period of 1024 ticks. Everything runs on one system clock, and the counters only advance on a single-cycle tick strobe.

Top module: `sup_wdt_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rst_n_o` is 0 and `wdo_n_o` is 1.
- R2: After a reset cause ends, `rst_n_o` stays 0 for 512 ticks when `rst_len_long_i` is 0, or for 2048 ticks when it is 1, and then goes to 1.
- R3: While `pfail_i` is 1, `rst_n_o` is 0, `wdo_n_o` is 1 and the watchdog counter is held at zero.
- R4: After every reset release, the watchdog period is the long grace value (16384 ticks in internal mode, 4096 ticks in external mode) until the first edge on `wdi_i`. This includes the release of a reset caused by a watchdog expiry.
- R5: When the watchdog counter reaches its period, `wdo_n_o` goes to 0 and `rst_n_o` goes to 0 on the next cycle, starting a reset pulse of the selected length.
- R6: Once `wdo_n_o` is 0, it stays 0 through the resulting reset pulse and afterwards, until the next edge on `wdi_i` in either direction or until `pfail_i` is asserted.
- R7: In internal mode (`mode_ext_i` = 0), after the first edge following reset, the period is 1024 ticks when `per_long_i` is 0 and stays 16384 ticks when `per_long_i` is 1.
- R8: Every edge on `wdi_i`, rising or falling, restarts the watchdog count, so kicks spaced closer than the period never cause an expiry.
- R9: In external mode (`mode_ext_i` = 1), the grace period is 4096 ticks and the normal period is 1024 ticks.
- R10: The reset and watchdog counters advance only in cycles where `tick_i` is 1. With no ticks, reset stays asserted indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| tick_i | input | 1 | Single-cycle timebase strobe |
| mode_ext_i | input | 1 | 1: external-clock tick counts, 0: internal fixed periods |
| per_long_i | input | 1 | Internal mode: 1 selects the long normal period |
| rst_len_long_i | input | 1 | 1: 2048-tick reset pulse, 0: 512-tick reset pulse |
| wdi_i | input | 1 | Watchdog input, asynchronous, any edge is a kick |
| pfail_i | input | 1 | Supply-fail flag, active high |
| rst_n_o | output | 1 | Active-low reset output |
| wdo_n_o | output | 1 | Active-low watchdog status, latched low on expiry |

## Verification
The hardest situation to reach is a reset caused by a watchdog expiry. That reset has to re-arm the long grace period, while the status output must stay latched low through it. To reach it, the bench first lets the full grace period run out with no kicks. It waits for the self-inflicted reset to end, then waits longer than the short period without kicking. Only after that does it toggle the input and check that the status output clears. The short period is also checked on its own. That test follows exactly one kick, so that the 1024-tick expiry is seen separately from the 16384-tick grace expiry.

// File: rtl/sup_wdt_pkg.sv
package sup_wdt_pkg;

  typedef enum logic [0:0] {
    RG_RUN  = 1'b0,
    RG_HOLD = 1'b1
  } rg_state_e;

  function automatic int cnt_width(input int max_count);
    return (max_count < 2) ? 1 : $clog2(max_count + 1);
  endfunction

endpackage

// File: rtl/sup_wdt_sync.sv
module sup_wdt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic edge_o
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign edge_o = sh_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/sup_wdt_rstgen.sv
module sup_wdt_rstgen #(
  parameter int SHORT_LEN = 512,
  parameter int LONG_LEN  = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic len_long_i,
  input  logic hold_i,
  input  logic trig_i,
  output logic active_o
);
  import sup_wdt_pkg::*;

  localparam int CW = cnt_width(LONG_LEN);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LEN - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_LEN - 1);

  rg_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = len_long_i ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= RG_HOLD;
      cnt_q <= '0;
    end else if (hold_i || trig_i) begin
      st_q  <= RG_HOLD;
      cnt_q <= '0;
    end else if (st_q == RG_HOLD && tick_i) begin
      if (cnt_q >= last) begin
        st_q  <= RG_RUN;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = (st_q == RG_HOLD);

  AST_HOLD_FORCES: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> active_o); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LONG_LAST); // R2
  AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !hold_i && !trig_i) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/sup_wdt_dog.sv
module sup_wdt_dog #(
  parameter int EXT_NORM  = 1024,
  parameter int EXT_GRACE = 4096,
  parameter int INT_SHORT = 1024,
  parameter int INT_LONG  = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic mode_ext_i,
  input  logic per_long_i,
  input  logic in_rst_i,
  input  logic pfail_i,
  input  logic kick_i,
  output logic expire_o,
  output logic wdo_n_o
);
  import sup_wdt_pkg::*;

  localparam int MAXP = (INT_LONG > EXT_GRACE) ? INT_LONG : EXT_GRACE;
  localparam int CW   = cnt_width(MAXP);
  localparam logic [CW-1:0] EN_LAST = CW'(EXT_NORM - 1);
  localparam logic [CW-1:0] EG_LAST = CW'(EXT_GRACE - 1);
  localparam logic [CW-1:0] IS_LAST = CW'(INT_SHORT - 1);
  localparam logic [CW-1:0] IL_LAST = CW'(INT_LONG - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          grace_q;
  logic          expire_q;
  logic          wdo_q;
  logic          hit;

  always_comb begin
    if (mode_ext_i) last = grace_q ? EG_LAST : EN_LAST;
    else            last = (grace_q || per_long_i) ? IL_LAST : IS_LAST;
  end

  assign hit = !in_rst_i && !pfail_i && !kick_i && tick_i && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || in_rst_i) grace_q <= 1'b1;
    else if (kick_i)     grace_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || in_rst_i || pfail_i || kick_i) cnt_q <= '0;
    else if (hit)                             cnt_q <= '0;
    else if (tick_i)                          cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) expire_q <= 1'b0;
    else     expire_q <= hit;
  end

  always_ff @(posedge clk) begin
    if (rst)                  wdo_q <= 1'b1;
    else if (pfail_i)         wdo_q <= 1'b1;
    else if (kick_i)          wdo_q <= 1'b1;
    else if (hit)             wdo_q <= 1'b0;
  end

  assign expire_o = expire_q;
  assign wdo_n_o  = wdo_q;

  AST_WDO_PFAIL: assert property (@(posedge clk) disable iff (rst)
    pfail_i |=> wdo_n_o); // R3
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    kick_i |=> (wdo_n_o && cnt_q == '0)); // R8
  AST_HELD_IN_RST: assert property (@(posedge clk) disable iff (rst)
    in_rst_i |=> (cnt_q == '0 && grace_q)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= IL_LAST || cnt_q <= EG_LAST); // R7
  AST_WDO_LATCH: assert property (@(posedge clk) disable iff (rst)
    (!wdo_n_o && !kick_i && !pfail_i) |=> !wdo_n_o); // R6

endmodule

// File: rtl/sup_wdt_top.sv
module sup_wdt_top #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_SHORT   = 512,
  parameter int RST_LONG    = 2048,
  parameter int EXT_NORM    = 1024,
  parameter int EXT_GRACE   = 4096,
  parameter int INT_SHORT   = 1024,
  parameter int INT_LONG    = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic mode_ext_i,
  input  logic per_long_i,
  input  logic rst_len_long_i,
  input  logic wdi_i,
  input  logic pfail_i,
  output logic rst_n_o,
  output logic wdo_n_o
);

  logic kick;
  logic expire;
  logic in_rst;

  sup_wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (wdi_i),
    .edge_o  (kick)
  );

  sup_wdt_rstgen #(.SHORT_LEN(RST_SHORT), .LONG_LEN(RST_LONG)) u_rstgen (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .len_long_i (rst_len_long_i),
    .hold_i     (pfail_i),
    .trig_i     (expire),
    .active_o   (in_rst)
  );

  sup_wdt_dog #(
    .EXT_NORM  (EXT_NORM),
    .EXT_GRACE (EXT_GRACE),
    .INT_SHORT (INT_SHORT),
    .INT_LONG  (INT_LONG)
  ) u_dog (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .mode_ext_i (mode_ext_i),
    .per_long_i (per_long_i),
    .in_rst_i   (in_rst),
    .pfail_i    (pfail_i),
    .kick_i     (kick),
    .expire_o   (expire),
    .wdo_n_o    (wdo_n_o)
  );

  assign rst_n_o = !in_rst;

  AST_EXPIRY_RESETS: assert property (@(posedge clk) disable iff (rst)
    $fell(wdo_n_o) |=> !rst_n_o); // R5
  AST_PFAIL_RESET: assert property (@(posedge clk) disable iff (rst)
    pfail_i |=> !rst_n_o); // R3

endmodule

// File: tb/sup_wdt_top_tb.sv
module sup_wdt_top_tb;

  logic clk = 1'b0;
  logic rst, tick_i, mode_ext_i, per_long_i, rst_len_long_i, wdi_i, pfail_i;
  logic rst_n_o, wdo_n_o;
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;

  always #5 clk = ~clk;

  sup_wdt_top u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .mode_ext_i(mode_ext_i),
    .per_long_i(per_long_i), .rst_len_long_i(rst_len_long_i),
    .wdi_i(wdi_i), .pfail_i(pfail_i), .rst_n_o(rst_n_o), .wdo_n_o(wdo_n_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 195000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<195000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rel(output int n);
    n = 0;
    while (rst_n_o !== 1'b1 && n < 6000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic kick();
    wdi_i = ~wdi_i;
  endtask

  task automatic restart(input bit long_len);
    int n;
    rst_len_long_i = long_len;
    pfail_i = 1'b1;
    waitn(4);
    pfail_i = 1'b0;
    wait_rel(n);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(rst_n_o == 1'b0, "R1 rst_n in reset", rst_n_o, 0);
    chk(wdo_n_o == 1'b1, "R1 wdo_n in reset", wdo_n_o, 1);
  endtask

  task automatic t_reset_len();
    int n;
    rst = 1'b0;
    @(negedge clk);
    chk(rst_n_o == 1'b0, "R1 rst_n after reset", rst_n_o, 0);
    wait_rel(n);
    chk(n >= 505 && n <= 518, "R2 short pulse", n, 512);
    rst_len_long_i = 1'b1;
    pfail_i = 1'b1;
    waitn(3);
    pfail_i = 1'b0;
    wait_rel(n);
    chk(n >= 2041 && n <= 2054, "R2 long pulse", n, 2048);
    rst_len_long_i = 1'b0;
  endtask

  task automatic t_no_tick();
    int n;
    tick_i = 1'b0;
    pfail_i = 1'b1;
    waitn(3);
    pfail_i = 1'b0;
    waitn(3000);
    chk(rst_n_o == 1'b0, "R10 no ticks keeps reset", rst_n_o, 0);
    tick_i = 1'b1;
    wait_rel(n);
    chk(n >= 505 && n <= 518, "R10 release after ticks", n, 512);
  endtask

  task automatic t_grace_and_expiry();
    mode_ext_i = 1'b0; per_long_i = 1'b0;
    restart(1'b0);
    waitn(2000);
    chk(wdo_n_o == 1'b1 && rst_n_o == 1'b1, "R4 grace beyond short period", wdo_n_o, 1);
    waitn(16384 - 2000 - 8);
    chk(wdo_n_o == 1'b1, "R4 before grace end", wdo_n_o, 1);
    waitn(16);
    chk(wdo_n_o == 1'b0, "R5 wdo after grace expiry", wdo_n_o, 0);
    chk(rst_n_o == 1'b0, "R5 reset after expiry", rst_n_o, 0);
    begin int n; wait_rel(n); end
    waitn(2000);
    chk(rst_n_o == 1'b1, "R4 grace re-armed after expiry reset", rst_n_o, 1);
    chk(wdo_n_o == 1'b0, "R6 wdo latched low", wdo_n_o, 0);
    pfail_i = 1'b1;
    waitn(3);
    chk(wdo_n_o == 1'b1, "R3 pfail forces wdo high", wdo_n_o, 1);
    chk(rst_n_o == 1'b0, "R3 pfail forces reset", rst_n_o, 0);
    pfail_i = 1'b0;
    begin int n; wait_rel(n); end
  endtask

  task automatic t_latch_clears_on_edge();
    restart(1'b0);
    waitn(16384 + 8);
    chk(wdo_n_o == 1'b0, "R5 expiry again", wdo_n_o, 0);
    begin int n; wait_rel(n); end
    waitn(20);
    chk(wdo_n_o == 1'b0, "R6 still low after reset pulse", wdo_n_o, 0);
    kick();
    waitn(6);
    chk(wdo_n_o == 1'b1, "R6 edge releases wdo", wdo_n_o, 1);
  endtask

  task automatic t_short_period();
    restart(1'b0);
    kick();
    waitn(1016);
    chk(wdo_n_o == 1'b1, "R7 before short expiry", wdo_n_o, 1);
    waitn(16);
    chk(wdo_n_o == 1'b0, "R7 short expiry", wdo_n_o, 0);
    per_long_i = 1'b1;
    restart(1'b0);
    kick();
    waitn(2000);
    chk(wdo_n_o == 1'b1, "R7 long select no short expiry", wdo_n_o, 1);
    per_long_i = 1'b0;
  endtask

  task automatic t_kicks();
    restart(1'b0);
    kick();
    for (int i = 0; i < 10; i++) begin
      waitn(700);
      kick();
    end
    waitn(5);
    chk(wdo_n_o == 1'b1, "R8 regular kicks keep wdo", wdo_n_o, 1);
    chk(rst_n_o == 1'b1, "R8 regular kicks keep reset off", rst_n_o, 1);
  endtask

  task automatic t_ext_mode();
    mode_ext_i = 1'b1;
    restart(1'b0);
    waitn(4090);
    chk(wdo_n_o == 1'b1, "R9 ext grace not expired", wdo_n_o, 1);
    waitn(16);
    chk(wdo_n_o == 1'b0, "R9 ext grace expiry", wdo_n_o, 0);
    begin int n; wait_rel(n); end
    kick();
    waitn(1016);
    chk(wdo_n_o == 1'b1, "R9 ext before normal expiry", wdo_n_o, 1);
    waitn(16);
    chk(wdo_n_o == 1'b0, "R9 ext normal expiry", wdo_n_o, 0);
    mode_ext_i = 1'b0;
  endtask

  initial begin
    rst = 1'b1; tick_i = 1'b1; mode_ext_i = 1'b0; per_long_i = 1'b0;
    rst_len_long_i = 1'b0; wdi_i = 1'b0; pfail_i = 1'b0;
    waitn(3);
    t_reset_state();
    t_reset_len();
    t_no_tick();
    t_grace_and_expiry();
    t_latch_clears_on_edge();
    t_short_period();
    t_kicks();
    t_ext_mode();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule